// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the SCL clock of an I2C controller from a reference clock. The low and high halves of each SCL period come from separate counts in one bus-clock word, so duty cycle and rate are set together. A period always lasts the low count plus the high count plus two reference cycles. With a 16 MHz reference the words 0x4F4F, 0x0F17 and 0x0509 give 100 kHz, 400 kHz and 1 MHz.

The block does not drive the pad itself. It raises `scl_oe` while SCL must be pulled low, and it reads back the already synchronized line level on `scl_in`. A target that holds SCL low stretches the high half, because the high count only advances while the line is seen high. The bit engine that uses this block gets two single-cycle strobes. One marks the middle of each high half, for sampling SDA. The other marks the first cycle of each low half, for changing SDA.

A start-hold count sets how long SCL stays released after the bit engine asks for a START or repeated START, so that SDA can be held low before the first falling edge. Timing words are captured only while the block is disabled.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_oe`, `mid_stb` and `fall_stb` are all 0.
- R2: Bits [7:0] of `bus_clk_cfg` (count L) set the low half. `scl_oe` stays 1 for exactly L+1 consecutive cycles.
- R3: Bits [15:8] (count H) set the high half. Without stretching, the high half lasts H+1 cycles and successive `fall_stb` pulses are L+H+2 cycles apart.
- R4: A high-half cycle in which `scl_in` is 0 does not advance the high count. Each such cycle lengthens the period by one cycle.
- R5: `mid_stb` pulses once per high half. It pulses in the cycle where `scl_in` is 1 and H−⌊H/2⌋ line-high cycles of that half have already elapsed.
- R6: `fall_stb` pulses in the first cycle of every low half, and only there.
- R7: `start_req` is accepted only while enabled and parked with SCL released. The first low half then begins S+1 rising edges after the edge that samples the request, where S is `hold_cfg`. At any other time `start_req` has no effect.
- R8: If `run` is 0 when a high half ends, the block parks with SCL released and gives no strobes until the next accepted `start_req`.
- R9: `bus_clk_cfg` and `hold_cfg` are captured only in cycles where `enable` is 0. Changes made while enabled do not alter the running period.
- R10: One cycle after `enable` is sampled 0, `scl_oe` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; the timing words are captured while it is 0 |
| run | input | 1 | Keep clocking after the current high half |
| start_req | input | 1 | Start or repeated-start request, sampled while parked |
| bus_clk_cfg | input | 2*CW | [CW-1:0] low count, [2*CW-1:CW] high count |
| hold_cfg | input | CW | Start-hold count |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| mid_stb | output | 1 | Mid-high strobe for sampling SDA |
| fall_stb | output | 1 | Low-half start strobe for changing SDA |

## Verification
The bench uses the default count width of eight bits. This is enough for all three 16 MHz rate words and their start-hold counts, giving periods of 16, 40 and 160 reference cycles, so every standard rate is run at full length within a short simulation. A behavioural model that counts elapsed cycles upward is compared with the design on every clock. Directed phases then measure the period, the low-half length, the strobe position and the start-hold delay, and they exercise stretching, parking, repeated starts and timing words changed while enabled.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            run,
  input  logic            start_req,
  input  logic [2*CW-1:0] bus_clk_cfg,
  input  logic [CW-1:0]   hold_cfg,
  input  logic            scl_in,
  output logic            scl_oe,
  output logic            mid_stb,
  output logic            fall_stb
);

  typedef enum logic [1:0] {ST_PARK, ST_HOLD, ST_LOW, ST_HIGH} phase_t;

  phase_t         ph;
  logic [CW-1:0]  lo_q, hi_q, hold_q, cnt;
  logic           cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      hold_q <= '0;
    end else if (!enable) begin
      lo_q   <= bus_clk_cfg[CW-1:0];
      hi_q   <= bus_clk_cfg[2*CW-1:CW];
      hold_q <= hold_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= ST_PARK;
      cnt <= '0;
    end else if (!enable) begin
      ph  <= ST_PARK;
      cnt <= '0;
    end else begin
      case (ph)
        ST_PARK: if (start_req) begin
          ph  <= ST_HOLD;
          cnt <= hold_q;
        end
        ST_HOLD: if (cnt_zero) begin
          ph  <= ST_LOW;
          cnt <= lo_q;
        end else cnt <= cnt - 1'b1;
        ST_LOW: if (cnt_zero) begin
          ph  <= ST_HIGH;
          cnt <= hi_q;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (scl_in) begin
          if (cnt_zero) begin
            ph  <= run ? ST_LOW : ST_PARK;
            cnt <= run ? lo_q : '0;
          end else cnt <= cnt - 1'b1;
        end
        default: ph <= ST_PARK;
      endcase
    end
  end

  assign scl_oe   = (ph == ST_LOW);
  assign fall_stb = (ph == ST_LOW) && (cnt == lo_q);
  assign mid_stb  = (ph == ST_HIGH) && scl_in && (cnt == (hi_q >> 1));

  // R10
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !mid_stb && !fall_stb));

  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph == ST_HIGH && !scl_in) |=> (ph == ST_HIGH && $stable(cnt)));

  // R6
  fall_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $rose(scl_oe));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mid_stb, fall_stb}));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable({hi_q, lo_q, hold_q}));

endmodule

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
  logic clk = 0, rst_n = 0, en = 0, run = 0, start = 0, stretch = 0;
  logic [15:0] cfg = 16'h0509;
  logic [7:0] hold = 8'h06;
  logic scl_in, scl_oe, mid_stb, fall_stb;
  int checks = 0, errs = 0, cyc = 0;
  int last_fall = 0, last_period = 0, low_run = 0, last_low = 0;
  int hi_start = 0, mid_off = -1, fall_cnt = 0;
  bit prev_oe = 0;
  int m_ph = 0, m_e = 0, m_lo = 0, m_hi = 0, m_hold = 0;

  always #5 clk = ~clk;
  assign scl_in = !scl_oe && !stretch;

  scl_clock_gen #(.CW(8)) u0 (.clk(clk), .rst_n(rst_n), .enable(en), .run(run),
    .start_req(start), .bus_clk_cfg(cfg), .hold_cfg(hold), .scl_in(scl_in),
    .scl_oe(scl_oe), .mid_stb(mid_stb), .fall_stb(fall_stb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  // behavioural model: elapsed-cycle counting per phase (0 park,1 hold,2 low,3 high)
  always @(posedge clk) begin
    bit line_hi;
    cyc++;
    line_hi = (m_ph != 2) && !stretch;
    if (!rst_n) begin
      m_ph = 0; m_e = 0; m_lo = 0; m_hi = 0; m_hold = 0;
    end else if (!en) begin
      m_ph = 0; m_e = 0;
      m_lo = cfg[7:0]; m_hi = cfg[15:8]; m_hold = hold;
    end else begin
      case (m_ph)
        0: if (start) begin m_ph = 1; m_e = 0; end
        1: if (m_e == m_hold) begin m_ph = 2; m_e = 0; end else m_e++;
        2: if (m_e == m_lo) begin m_ph = 3; m_e = 0; end else m_e++;
        default: if (line_hi) begin
          if (m_e == m_hi) begin m_ph = run ? 2 : 0; m_e = 0; end else m_e++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    bit line_hi;
    line_hi = (m_ph != 2) && !stretch;
    chk("R2 scl_oe", scl_oe, m_ph == 2);
    chk("R6 fall_stb", fall_stb, (m_ph == 2) && (m_e == 0));
    chk("R5 mid_stb", mid_stb, (m_ph == 3) && line_hi && (m_e == m_hi - m_hi / 2));
    if (fall_stb) begin last_period = cyc - last_fall; last_fall = cyc; fall_cnt++; end
    if (scl_oe) low_run++;
    else if (prev_oe) begin last_low = low_run; low_run = 0; hi_start = cyc; end
    if (mid_stb) mid_off = cyc - hi_start;
    prev_oe = scl_oe;
  end

  task automatic do_start(input int s);
    int c0;
    c0 = cyc;
    start = 1; tick(); start = 0;
    while (!scl_oe) tick();
    chk("R7 start hold delay", cyc - c0, s + 2);
  endtask

  initial begin
    tick();
    chk("R1 scl_oe in reset", scl_oe, 0);
    chk("R1 strobes in reset", {mid_stb, fall_stb}, 0);
    tick(2);
    rst_n = 1; tick();
    chk("R1 scl_oe after reset", scl_oe, 0);
    en = 1; run = 1; tick();
    do_start(6);
    tick(70);
    chk("R3 period 0x0509", last_period, 16);
    chk("R2 low length 0x0509", last_low, 10);
    // stretching
    while (!fall_stb) tick();
    while (scl_oe) tick();
    stretch = 1; tick(7); stretch = 0;
    while (!fall_stb) tick();
    chk("R4 stretched period", last_period, 23);
    // config change while enabled
    cfg = 16'h0F17; hold = 8'h0A;
    tick(50);
    chk("R9 period unchanged", last_period, 16);
    en = 0; tick();
    chk("R10 released after disable", {scl_oe, mid_stb, fall_stb}, 0);
    tick();
    en = 1; tick();
    do_start(10);
    tick(130);
    chk("R3 period 0x0F17", last_period, 40);
    chk("R2 low length 0x0F17", last_low, 24);
    chk("R5 mid offset", mid_off, 8);
    // parking and repeated start
    run = 0; tick(45);
    begin
      int fc;
      fc = fall_cnt;
      start = 0; tick(100);
      chk("R8 no falls while parked", fall_cnt, fc);
      chk("R8 released while parked", scl_oe, 0);
    end
    run = 1;
    do_start(10);
    tick(90);
    chk("R3 period after repeated start", last_period, 40);
    // 100 kHz
    en = 0; cfg = 16'h4F4F; hold = 8'h4D; tick(2);
    en = 1; tick();
    do_start(77);
    tick(400);
    chk("R3 period 0x4F4F", last_period, 160);
    chk("R2 low length 0x4F4F", last_low, 80);
    while (!fall_stb) tick();
    tick(20);
    start = 1; tick(); start = 0;
    tick(330);
    chk("R7 start ignored while running", last_period, 160);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule